// File: doc/BRIEF.md
# Elastic DRAM Refresh Scheduler

This block decides when a DRAM rank gets its refresh commands. Time is cut into fixed refresh intervals, and a fixed number of intervals forms a budget window. One refresh is owed as each interval begins. Rather than firing a refresh at every interval boundary, the block banks the owed refreshes as credit and spends them while the rank is quiet. A quiet spell is the idle input held high for a set number of consecutive cycles.

The last interval of every window is a catch-up zone. In it, every refresh still owed is requested back to back, flagged as urgent, whether or not the rank is idle. The command issuer must give urgent requests priority over all other traffic. The issuer accepts a request with a one-cycle acknowledge. After each accepted refresh, the block raises a block signal for the refresh completion time, which keeps other commands off the rank, and it raises no new request until that time has passed.

The parameters are counted in clock cycles: interval length, busy time, refreshes per window and the length of a quiet spell. The forced drain fits inside the final interval only if WINDOW_CNT × (BUSY_CYC + 1) is less than INTERVAL_CYC, so the parameters must be chosen to meet that.

Top module: `elastic_refresh_sched`

## Requirements
- R1: While reset is high and in the first cycle after it is released, ref_req_o, ref_urgent_o and rank_block_o are low.
- R2: One credit is earned in the first cycle of every interval, counting that first cycle after reset as cycle 0. It becomes usable one cycle later. Each accepted refresh consumes one credit. With no credit, no request is raised.
- R3: Outside the final interval, a non-urgent request is raised when rank_idle_i was sampled high on the last LULL_CYC clock edges, is still high, credit is nonzero and the rank is not blocked. The request falls in the same cycle that rank_idle_i goes low.
- R4: The final interval of each window is interval index WINDOW_CNT-1. Throughout it, while credit is nonzero and the rank is not blocked, the request and the urgent flag are high, whatever rank_idle_i does. They stay high until acknowledged.
- R5: A refresh is accepted when ref_ack_i is high in a cycle where ref_req_o is high. rank_block_o is then high for exactly BUSY_CYC cycles starting the next cycle, and ref_req_o is low whenever rank_block_o is high.
- R6: ref_ack_i is ignored when ref_req_o is low. It consumes no credit and does not raise rank_block_o.
- R7: When every request is acknowledged at once, each window of WINDOW_CNT × INTERVAL_CYC cycles from reset holds exactly WINDOW_CNT accepted refreshes.
- R8: Credit saturates at WINDOW_CNT. After any length of time with no acknowledgements, at most WINDOW_CNT refreshes are owed.
- R9: ref_urgent_o is high only together with ref_req_o, and only during a final interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rank_idle_i | input | 1 | Rank has no pending traffic this cycle |
| ref_ack_i | input | 1 | Command issuer accepts the refresh request this cycle |
| ref_req_o | output | 1 | A refresh is requested |
| ref_urgent_o | output | 1 | The request is a forced catch-up and outranks other traffic |
| rank_block_o | output | 1 | Refresh completion time in progress; no other command may target the rank |

## Verification
The bench builds the block with a 64-cycle interval, a 6-cycle busy time, 8 refreshes per window and a 4-cycle quiet threshold. These values shrink a window to 512 cycles, so five whole windows fit in a short run. A full eight-refresh forced drain (56 cycles) still fits inside one final interval. With them the bench reaches exact refresh counts per window under silent, bursty and always-idle traffic, as well as the forced drain and the urgent flag. It also covers saturation across an unacknowledged window and the exact cycles where credit arrives and the block signal ends.

// File: rtl/erf_pkg.sv
package erf_pkg;

    // Kind of refresh request raised in the current cycle
    typedef enum logic [1:0] {
        RQ_NONE  = 2'd0,
        RQ_LULL  = 2'd1,
        RQ_FORCE = 2'd2
    } rq_kind_t;

    // Events produced by the interval/window timer
    typedef struct packed {
        logic earn;       // first cycle of an interval
        logic final_ivl;  // inside the catch-up interval of a window
    } ivl_evt_t;

    // Bits needed to hold values 0..max_val
    function automatic int cnt_bits(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

    // Request priority: forced catch-up over opportunistic lull use
    function automatic rq_kind_t pick_kind(input logic have_credit,
                                           input logic blocked,
                                           input logic final_ivl,
                                           input logic lull);
        if (!have_credit || blocked) return RQ_NONE;
        if (final_ivl)               return RQ_FORCE;
        if (lull)                    return RQ_LULL;
        return RQ_NONE;
    endfunction

endpackage

// File: rtl/erf_interval_timer.sv
module erf_interval_timer
    import erf_pkg::*;
#(
    parameter int INTERVAL_CYC = 975,
    parameter int WINDOW_CNT   = 8
) (
    input  logic     clk_i,
    input  logic     rst_i,
    output ivl_evt_t evt_o
);
    localparam int IW = cnt_bits(INTERVAL_CYC - 1);
    localparam int WW = cnt_bits(WINDOW_CNT - 1);
    localparam logic [IW-1:0] ILAST = IW'(INTERVAL_CYC - 1);
    localparam logic [WW-1:0] WLAST = WW'(WINDOW_CNT - 1);

    logic [IW-1:0] icnt_q;
    logic [WW-1:0] wcnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            icnt_q <= '0;
            wcnt_q <= '0;
        end else if (icnt_q == ILAST) begin
            icnt_q <= '0;
            wcnt_q <= (wcnt_q == WLAST) ? '0 : wcnt_q + 1'b1;
        end else begin
            icnt_q <= icnt_q + 1'b1;
        end
    end

    always_comb begin
        evt_o.earn      = (icnt_q == '0);
        evt_o.final_ivl = (wcnt_q == WLAST);
    end

    // R4: a window ends by starting a fresh, non-final interval
    p_window_wrap_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (icnt_q == ILAST && wcnt_q == WLAST) |=> (evt_o.earn && !evt_o.final_ivl));

    // R2: an earn event is followed by a non-earn cycle when intervals are long
    p_earn_single_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_o.earn |=> !evt_o.earn);

endmodule

// File: rtl/erf_credit.sv
module erf_credit
    import erf_pkg::*;
#(
    parameter int WINDOW_CNT = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic earn_i,
    input  logic take_i,
    output logic nonzero_o
);
    localparam int CW = cnt_bits(WINDOW_CNT);
    localparam logic [CW-1:0] CMAX = CW'(WINDOW_CNT);

    logic [CW-1:0] credit_q;
    logic [CW-1:0] credit_d;

    always_comb begin
        credit_d = credit_q;
        if (take_i && credit_q != '0) credit_d = credit_d - 1'b1;
        if (earn_i && credit_d != CMAX) credit_d = credit_d + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) credit_q <= '0;
        else       credit_q <= credit_d;
    end

    assign nonzero_o = (credit_q != '0);

    // R8: a full bank stays full when more credit arrives without a take
    p_credit_sat_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (earn_i && !take_i && credit_q == CMAX) |=> (credit_q == CMAX));

    // R2: an accepted refresh without a new earn lowers the bank by one
    p_take_dec_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (take_i && !earn_i) |=> (credit_q == $past(credit_q) - 1'b1));

    // R2: a take is only seen while credit exists
    p_take_has_credit_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        take_i |-> nonzero_o);

endmodule

// File: rtl/erf_lull_detect.sv
module erf_lull_detect
    import erf_pkg::*;
#(
    parameter int LULL_CYC = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic rank_idle_i,
    output logic lull_o
);
    localparam int RW = cnt_bits(LULL_CYC);
    localparam logic [RW-1:0] RMAX = RW'(LULL_CYC);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)             run_q <= '0;
        else if (!rank_idle_i) run_q <= '0;
        else if (run_q != RMAX) run_q <= run_q + 1'b1;
    end

    assign lull_o = rank_idle_i && (run_q == RMAX);

    // R3: a lull needs the idle input to have been high on the previous edge
    p_lull_history_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        lull_o |-> $past(rank_idle_i));

    // R3: dropping idle ends any lull in the same cycle
    p_lull_drop_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !rank_idle_i |-> !lull_o);

endmodule

// File: rtl/erf_busy_timer.sv
module erf_busy_timer
    import erf_pkg::*;
#(
    parameter int BUSY_CYC = 44
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic block_o
);
    localparam int BW = cnt_bits(BUSY_CYC);
    localparam logic [BW-1:0] BLEN = BW'(BUSY_CYC);

    logic [BW-1:0] left_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)              left_q <= '0;
        else if (start_i)       left_q <= BLEN;
        else if (left_q != '0)  left_q <= left_q - 1'b1;
    end

    assign block_o = (left_q != '0);

    // R5: the busy period begins only from an accepted refresh
    p_block_origin_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(block_o) |-> $past(start_i));

    // R5: an accepted refresh blocks the rank on the next cycle
    p_block_start_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> block_o);

endmodule

// File: rtl/elastic_refresh_sched.sv
module elastic_refresh_sched
    import erf_pkg::*;
#(
    parameter int INTERVAL_CYC = 975,
    parameter int BUSY_CYC     = 44,
    parameter int WINDOW_CNT   = 8,
    parameter int LULL_CYC     = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic rank_idle_i,
    input  logic ref_ack_i,
    output logic ref_req_o,
    output logic ref_urgent_o,
    output logic rank_block_o
);
    ivl_evt_t evt;
    logic     have_credit;
    logic     lull;
    logic     blocked;
    logic     take;
    rq_kind_t kind;

    erf_interval_timer #(
        .INTERVAL_CYC (INTERVAL_CYC),
        .WINDOW_CNT   (WINDOW_CNT)
    ) u_timer (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .evt_o (evt)
    );

    erf_credit #(
        .WINDOW_CNT (WINDOW_CNT)
    ) u_credit (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .earn_i    (evt.earn),
        .take_i    (take),
        .nonzero_o (have_credit)
    );

    erf_lull_detect #(
        .LULL_CYC (LULL_CYC)
    ) u_lull (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .rank_idle_i (rank_idle_i),
        .lull_o      (lull)
    );

    erf_busy_timer #(
        .BUSY_CYC (BUSY_CYC)
    ) u_busy (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (take),
        .block_o (blocked)
    );

    always_comb begin
        kind         = pick_kind(have_credit, blocked, evt.final_ivl, lull);
        ref_req_o    = (kind != RQ_NONE);
        ref_urgent_o = (kind == RQ_FORCE);
        take         = ref_ack_i && ref_req_o;
        rank_block_o = blocked;
    end

    // R5: never request while the previous refresh is still completing
    p_no_req_blocked_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        rank_block_o |-> !ref_req_o);

    // R5: an accepted refresh drops the request and blocks next cycle
    p_accept_blocks_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (ref_ack_i && ref_req_o) |=> (rank_block_o && !ref_req_o));

    // R9: urgent only accompanies a request
    p_urgent_req_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        ref_urgent_o |-> ref_req_o);

    // R3: outside the catch-up interval a busy rank sees no request
    p_busy_quiet_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rank_idle_i && !evt.final_ivl) |-> !ref_req_o);

    // R6: an acknowledge with no request starts no busy period
    p_stray_ack_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (ref_ack_i && !ref_req_o && !rank_block_o) |=> !rank_block_o);

endmodule

// File: tb/tb_elastic_refresh_sched.sv
`timescale 1ns/1ps
module tb_elastic_refresh_sched;

    localparam int IVL   = 64;
    localparam int BUSY  = 6;
    localparam int NWIN  = 8;
    localparam int LULL  = 4;
    localparam int WIN   = IVL * NWIN;
    localparam int FINAL = IVL * (NWIN - 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rank_idle = 1'b0;
    logic ref_ack = 1'b0;
    logic req, urgent, block;

    int p = 0;
    int cur_p = 0;
    int n_chk = 0;
    int n_bad = 0;
    int wd = 0;
    int acc_total = 0;
    int win_acc [0:7];
    int mon_blk = 0;
    int mon_urg = 0;
    logic auto_ack = 1'b0;
    logic manual_ack = 1'b0;

    always #4 clk = ~clk;

    elastic_refresh_sched #(
        .INTERVAL_CYC (IVL),
        .BUSY_CYC     (BUSY),
        .WINDOW_CNT   (NWIN),
        .LULL_CYC     (LULL)
    ) dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .rank_idle_i  (rank_idle),
        .ref_ack_i    (ref_ack),
        .ref_req_o    (req),
        .ref_urgent_o (urgent),
        .rank_block_o (block)
    );

    always @(posedge clk) begin
        if (rst) p <= 0;
        else     p <= p + 1;
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 20000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung at cycle %0d, expected end before 20000", cur_p);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s at cycle %0d: got %0b expected %0b", tag, cur_p, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cur_p, act, exp);
        end
    endtask

    // One cycle: set idle, sample outputs mid-cycle, then drive ack
    task automatic step(input logic idle_v);
        @(posedge clk);
        #3;
        rank_idle = idle_v;
        #1;
        cur_p = p;
        if (block && req) mon_blk = mon_blk + 1;
        if (urgent && !req) mon_urg = mon_urg + 1;
        if (urgent && (cur_p % WIN) < FINAL) mon_urg = mon_urg + 1;
        ref_ack = manual_ack || (auto_ack && req);
        if (ref_ack && req) begin
            acc_total = acc_total + 1;
            if (cur_p / WIN < 8) win_acc[cur_p / WIN] = win_acc[cur_p / WIN] + 1;
        end
    endtask

    function automatic logic idle_of(input int mode, input int c);
        if (mode == 0) return 1'b0;
        if (mode == 1) return 1'b1;
        return ((c % 50) < 12);
    endfunction

    task automatic run_to(input int t, input int mode);
        while (cur_p < t) step(idle_of(mode, cur_p + 1));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        rank_idle = 1'b0;
        ref_ack = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 req in reset", req, 1'b0);
        chk("R1 block in reset", block, 1'b0);
        #1;
        rst = 1'b0;
        #1;
        cur_p = p;
        chk("R1 req after reset", req, 1'b0);
        chk("R1 urgent after reset", urgent, 1'b0);
        chk("R1 block after reset", block, 1'b0);
    endtask

    // Window 0: lull detection, idle drop, busy length, credit arrival, forced drain
    task automatic t_window0;
        run_to(9, 0);
        repeat (4) step(1'b1);
        chk("R3 no req before lull length", req, 1'b0);
        step(1'b1);
        chk("R3 lull req", req, 1'b1);
        chk("R3 lull req not urgent", urgent, 1'b0);
        step(1'b0);
        chk("R3 req drops with idle", req, 1'b0);
        repeat (4) step(1'b1);
        chk("R3 idle run restarts", req, 1'b0);
        auto_ack = 1'b1;
        step(1'b1);
        chk("R3 lull req again", req, 1'b1);
        step(1'b1);
        chk("R5 block after accept", block, 1'b1);
        chk("R5 no req while blocked", req, 1'b0);
        run_to(26, 1);
        chk("R5 block last busy cycle", block, 1'b1);
        step(1'b1);
        chk("R5 block ends after busy", block, 1'b0);
        chk("R2 no credit no req", req, 1'b0);
        run_to(64, 1);
        chk("R2 credit not yet usable", req, 1'b0);
        step(1'b1);
        chk("R2 credit usable next interval", req, 1'b1);
        step(1'b0);
        chk("R5 block second refresh", block, 1'b1);
        run_to(447, 0);
        chk("R4 no req before final interval", req, 1'b0);
        step(1'b0);
        chk("R4 forced req", req, 1'b1);
        chk("R4 forced urgent", urgent, 1'b1);
        run_to(454, 0);
        chk("R5 block through busy", block, 1'b1);
        step(1'b0);
        chk("R5 block released", block, 1'b0);
        chk("R4 next forced req", urgent, 1'b1);
        run_to(511, 0);
        chk("R4 drain complete", req, 1'b0);
        chk_int("R7 window 0 count", win_acc[0], NWIN);
    endtask

    // Window 1 bursty idle, window 2 always idle
    task automatic t_windows12;
        run_to(1015, 2);
        run_to(1023, 1);
        chk("R2 drained at window end", req, 1'b0);
        chk_int("R7 window 1 count", win_acc[1], NWIN);
        step(1'b1);
        chk("R2 credit lags interval start", req, 1'b0);
        step(1'b1);
        chk("R3 idle rank refreshes early", req, 1'b1);
        chk("R9 early refresh not urgent", urgent, 1'b0);
        run_to(1535, 1);
        chk_int("R7 window 2 count", win_acc[2], NWIN);
    endtask

    // Window 3/4: stray acks, unacked force, saturation
    task automatic t_saturate;
        int snap;
        auto_ack = 1'b0;
        run_to(1539, 0);
        manual_ack = 1'b1;
        repeat (5) step(1'b0);
        chk("R6 no req during stray ack", req, 1'b0);
        manual_ack = 1'b0;
        step(1'b0);
        chk("R6 stray ack no block", block, 1'b0);
        run_to(2000, 0);
        chk("R4 forced req held", req, 1'b1);
        chk("R4 forced urgent held", urgent, 1'b1);
        run_to(2048, 0);
        chk("R9 urgent clears at new window", urgent, 1'b0);
        step(1'b0);
        snap = acc_total;
        auto_ack = 1'b1;
        run_to(2110, 1);
        chk_int("R8 saturated refresh count", acc_total - snap, NWIN);
        step(1'b1);
        chk("R8 bank empty after drain", req, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) win_acc[i] = 0;
        t_reset();
        t_window0();
        t_windows12();
        t_saturate();
        chk_int("R5 req never while blocked", mon_blk, 0);
        chk_int("R9 urgent only with req in final interval", mon_urg, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule